// File: doc/BRIEF.md
# Two-Wire EEPROM Slave Write Engine

This block is the write side of a serial EEPROM slave on a two-wire bus. It oversamples SCL and SDA with the system clock and finds Start and Stop conditions. It decodes a device-select byte and takes a two-byte word address. Data bytes are collected in a page buffer, and the block acknowledges each byte by pulling SDA low through an open-drain enable.

The buffered page is written into the on-chip array in a single clock when Stop arrives. A timed programming interval then follows. While it runs, the busy output is high and the slave stays silent on the bus, so a bus master can poll for the acknowledge to learn when programming is done.

Page addressing wraps inside the 32-byte page: only the low five pointer bits advance, so extra bytes overwrite earlier ones. The array width is a parameter. Thirteen address bits give the 8 KiB configuration, and the default is smaller. The rest of the chip reads the array through a one-cycle registered lookup port.

Top module: `twp_eeprom_writer`

## Requirements
- R1: A Start (SDA falling while synchronized SCL is high) returns the slave to the device-select byte from any state and discards data buffered since the previous Start. A Stop (SDA rising while SCL is high) ends the transfer.
- R2: A device-select byte is acknowledged only when bits 7..4 equal 1010, bits 3..1 equal strap_i and bit 0 is 0. Otherwise it is not acknowledged, and the rest of the transfer up to the next Start is ignored: no acknowledge is given and nothing is written.
- R3: A device-select byte with bit 0 equal to 1 (a read request) is never acknowledged.
- R4: After an acknowledged select, two address bytes are each acknowledged. The word address is the low ADDR_W bits of {first byte, second byte}, and the upper bits are ignored.
- R5: Each data byte is acknowledged and stored at the pointer. Only the low 5 pointer bits then increment, wrapping within the 32-byte page, so a byte beyond the 32nd overwrites the earlier byte at the same offset.
- R6: The array is unchanged until Stop. At Stop, every buffered byte is written at once. A Stop with no data byte writes nothing and does not start a programming interval.
- R7: busy_o is low after reset and is high for exactly PROG_CYC clocks after a committing Stop.
- R8: While busy_o is high, no byte is acknowledged (not even a matching select) and nothing is buffered. Once busy_o falls, a matching select is acknowledged again.
- R9: peek_data_o shows the array byte at peek_addr_i one clock after the address is applied.
- R10: sda_oe_o is low after reset and is high only in the acknowledge slot. That slot runs from the SCL fall that ends the 8th bit of a byte to the SCL fall that ends the 9th.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used for oversampling |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| strap_i | input | 3 | Device strap compared with select bits 3..1 |
| peek_addr_i | input | ADDR_W | Array lookup address |
| sda_oe_o | output | 1 | High pulls SDA low (open-drain acknowledge) |
| busy_o | output | 1 | High during the programming interval |
| peek_data_o | output | 8 | Array byte at the previous lookup address |

## Verification
On every cycle, the embedded properties check several rules. The slave never drives SDA while busy, and it drives SDA only inside an acknowledge slot. A busy interval begins only after a Stop, and no Stop can commit while the timer is still counting. The page-select bits of the pointer do not change when a data byte is stored, and a select byte with the wrong family prefix is never acknowledged. The bench scenarios cover the rest: the strap match matrix, the stored contents after page wrap, repeated Start and ignored transfers, the exact length of the busy interval, and whether the array really stays unchanged before Stop. All of these are checked against a byte-level model of the array kept in the bench.

// File: rtl/twp_pkg.sv
package twp_pkg;

  localparam logic [3:0] TWP_FAMILY = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_AHI,
    ST_ALO,
    ST_DATA,
    ST_SKIP
  } twp_state_e;

  // select byte: family nibble, strap triple, direction bit (0 = write)
  function automatic logic twp_select_hit(input logic [7:0] b, input logic [2:0] strap);
    return (b[7:4] == TWP_FAMILY) && (b[3:1] == strap) && !b[0];
  endfunction

endpackage

// File: rtl/twp_line_sync.sv
module twp_line_sync #(
  parameter int SYNC_N = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);

  logic [SYNC_N-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q, scl_s, sda_s;

  assign scl_s = scl_ff[SYNC_N-1];
  assign sda_s = sda_ff[SYNC_N-1];

  // idle bus is high on both lines, so reset to 1 to avoid false events
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[SYNC_N-2:0], scl_i};
      sda_ff <= {sda_ff[SYNC_N-2:0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end
  end

  assign sda_lvl   = sda_s;
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_evt = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_evt  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/twp_byte_engine.sv
module twp_byte_engine
  import twp_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int PAGE_W = 5,
  localparam int PG_W  = ADDR_W - PAGE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_lvl,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic              busy,
  input  logic [2:0]        strap,
  output logic              ack_o,
  output logic              wr_en,
  output logic [PAGE_W-1:0] wr_off,
  output logic [7:0]        wr_data,
  output logic [PG_W-1:0]   page_idx,
  output logic              clr_buf,
  output logic              commit
);

  localparam logic [PAGE_W-1:0] OFF_ONE = 1;

  twp_state_e        state, next_state;
  logic [3:0]        bit_cnt;
  logic [7:0]        shreg, addr_hi;
  logic              ack_q, ack_phase, got_data, accept;
  logic [ADDR_W-1:0] ptr;
  logic              active, byte_done, ack_end;

  // low offset bits advance and wrap, page bits are held
  function automatic logic [ADDR_W-1:0] step_ptr(input logic [ADDR_W-1:0] p);
    return {p[ADDR_W-1:PAGE_W], p[PAGE_W-1:0] + OFF_ONE};
  endfunction

  function automatic logic [ADDR_W-1:0] word_addr(input logic [7:0] hi, input logic [7:0] lo);
    logic [15:0] w;
    w = {hi, lo};
    return w[ADDR_W-1:0];
  endfunction

  assign active    = (state != ST_IDLE);
  assign byte_done = active && scl_fall && !ack_phase && (bit_cnt == 4'd8);
  assign ack_end   = active && scl_fall && ack_phase;

  always_comb begin
    case (state)
      ST_DEV:                  accept = twp_select_hit(shreg, strap);
      ST_AHI, ST_ALO, ST_DATA: accept = 1'b1;
      default:                 accept = 1'b0;
    endcase
  end

  always_comb begin
    case (state)
      ST_DEV:  next_state = ack_q ? ST_AHI : ST_SKIP;
      ST_AHI:  next_state = ST_ALO;
      ST_ALO:  next_state = ST_DATA;
      ST_DATA: next_state = ST_DATA;
      ST_SKIP: next_state = ST_SKIP;
      default: next_state = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      bit_cnt   <= '0;
      shreg     <= '0;
      addr_hi   <= '0;
      ptr       <= '0;
      ack_q     <= 1'b0;
      ack_phase <= 1'b0;
      got_data  <= 1'b0;
    end else if (busy) begin
      state     <= ST_IDLE;
      bit_cnt   <= '0;
      ack_q     <= 1'b0;
      ack_phase <= 1'b0;
      got_data  <= 1'b0;
    end else if (start_evt) begin
      state     <= ST_DEV;
      bit_cnt   <= '0;
      ack_q     <= 1'b0;
      ack_phase <= 1'b0;
      got_data  <= 1'b0;
    end else if (stop_evt) begin
      state     <= ST_IDLE;
      bit_cnt   <= '0;
      ack_q     <= 1'b0;
      ack_phase <= 1'b0;
      got_data  <= 1'b0;
    end else if (active) begin
      if (scl_rise && !ack_phase && (bit_cnt < 4'd8)) begin
        shreg   <= {shreg[6:0], sda_lvl};
        bit_cnt <= bit_cnt + 4'd1;
      end
      if (byte_done) begin
        ack_phase <= 1'b1;
        ack_q     <= accept;
        case (state)
          ST_AHI:  addr_hi <= shreg;
          ST_ALO:  ptr     <= word_addr(addr_hi, shreg);
          ST_DATA: begin
            ptr      <= step_ptr(ptr);
            got_data <= 1'b1;
          end
          default: ;
        endcase
      end
      if (ack_end) begin
        ack_phase <= 1'b0;
        ack_q     <= 1'b0;
        bit_cnt   <= '0;
        state     <= next_state;
      end
    end
  end

  assign ack_o    = ack_q;
  assign wr_en    = byte_done && (state == ST_DATA);
  assign wr_off   = ptr[PAGE_W-1:0];
  assign wr_data  = shreg;
  assign page_idx = ptr[ADDR_W-1:PAGE_W];
  assign clr_buf  = start_evt && !busy;
  assign commit   = stop_evt && !busy && got_data;

  a_r10_ack_in_slot: assert property (@(posedge clk) disable iff (!rst_n)
    ack_q |-> ack_phase);

  a_r5_page_bits_held: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ptr[ADDR_W-1:PAGE_W] == $past(ptr[ADDR_W-1:PAGE_W]));

  a_r2_prefix_required: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && state == ST_DEV && shreg[7:4] != TWP_FAMILY) |=> !ack_q);

endmodule

// File: rtl/twp_page_store.sv
module twp_page_store #(
  parameter int ADDR_W = 11,
  parameter int PAGE_W = 5,
  localparam int PG_W  = ADDR_W - PAGE_W,
  localparam int PAGE  = 1 << PAGE_W,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [PAGE_W-1:0] wr_off,
  input  logic [7:0]        wr_data,
  input  logic [PG_W-1:0]   page_idx,
  input  logic              clr_buf,
  input  logic              commit,
  input  logic [ADDR_W-1:0] peek_addr,
  output logic [7:0]        peek_data
);

  logic [PAGE-1:0] vld;
  logic [7:0]      slot_q [PAGE];
  logic [7:0]      mem    [DEPTH];

  for (genvar g = 0; g < PAGE; g++) begin : g_slot
    logic hit;
    assign hit = wr_en && (wr_off == PAGE_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                vld[g] <= 1'b0;
      else if (clr_buf || commit) vld[g] <= 1'b0;
      else if (hit)               vld[g] <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (hit) slot_q[g] <= wr_data;
    end
  end

  // whole page lands in the array on the commit clock
  always_ff @(posedge clk) begin
    if (commit) begin
      for (int i = 0; i < PAGE; i++) begin
        if (vld[i]) mem[{page_idx, PAGE_W'(i)}] <= slot_q[i];
      end
    end
    peek_data <= mem[peek_addr];
  end

  a_r6_commit_has_data: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> (vld != '0));

endmodule

// File: rtl/twp_prog_timer.sv
module twp_prog_timer #(
  parameter int PROG_CYC = 2000,
  localparam int CNT_W   = $clog2(PROG_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic commit,
  output logic busy_o
);

  localparam logic [CNT_W-1:0] LOAD = CNT_W'(PROG_CYC);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (commit)     cnt <= LOAD;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign busy_o = (cnt != '0);

  a_r7_reload_only_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> cnt == '0);

endmodule

// File: rtl/twp_eeprom_writer.sv
module twp_eeprom_writer #(
  parameter int ADDR_W   = 11,
  parameter int PAGE_W   = 5,
  parameter int PROG_CYC = 2000,
  parameter int SYNC_N   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [2:0]        strap_i,
  input  logic [ADDR_W-1:0] peek_addr_i,
  output logic              sda_oe_o,
  output logic              busy_o,
  output logic [7:0]        peek_data_o
);

  localparam int PG_W = ADDR_W - PAGE_W;

  logic              sda_lvl, scl_rise, scl_fall, start_evt, stop_evt;
  logic              wr_en, clr_buf, commit, ack;
  logic [PAGE_W-1:0] wr_off;
  logic [7:0]        wr_data;
  logic [PG_W-1:0]   page_idx;

  twp_line_sync #(.SYNC_N(SYNC_N)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .sda_lvl   (sda_lvl),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_evt (start_evt),
    .stop_evt  (stop_evt)
  );

  twp_byte_engine #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .sda_lvl   (sda_lvl),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_evt (start_evt),
    .stop_evt  (stop_evt),
    .busy      (busy_o),
    .strap     (strap_i),
    .ack_o     (ack),
    .wr_en     (wr_en),
    .wr_off    (wr_off),
    .wr_data   (wr_data),
    .page_idx  (page_idx),
    .clr_buf   (clr_buf),
    .commit    (commit)
  );

  twp_page_store #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_off    (wr_off),
    .wr_data   (wr_data),
    .page_idx  (page_idx),
    .clr_buf   (clr_buf),
    .commit    (commit),
    .peek_addr (peek_addr_i),
    .peek_data (peek_data_o)
  );

  twp_prog_timer #(.PROG_CYC(PROG_CYC)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .commit (commit),
    .busy_o (busy_o)
  );

  assign sda_oe_o = ack;

  a_r8_silent_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !sda_oe_o);

  a_r7_busy_follows_stop: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(stop_evt));

endmodule

// File: tb/twp_eeprom_writer_tb_top.sv
module twp_eeprom_writer_tb_top;
  localparam int AW   = 8;
  localparam int DEP  = 1 << AW;
  localparam int PROG = 400;
  localparam int Q    = 4;

  logic          clk = 1'b0;
  logic          rst_n, scl, sda_m, sda_line, sda_oe, busy;
  logic [2:0]    strap;
  logic [AW-1:0] peek_addr;
  logic [7:0]    peek_data;

  int         vecs  = 0;
  int         fails = 0;
  logic [7:0] mdl   [DEP];
  bit         known [DEP];
  logic [7:0] pay   [64];

  always #5 clk = ~clk;

  assign sda_line = sda_m & ~sda_oe;

  twp_eeprom_writer #(.ADDR_W(AW), .PAGE_W(5), .PROG_CYC(PROG), .SYNC_N(2)) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_i       (scl),
    .sda_i       (sda_line),
    .strap_i     (strap),
    .peek_addr_i (peek_addr),
    .sda_oe_o    (sda_oe),
    .busy_o      (busy),
    .peek_data_o (peek_data)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vecs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q);
    scl   = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl   = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q);
    scl   = 1'b1; tick(Q);
    sda_m = 1'b1;
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(Q);
      scl = 1'b1; tick(Q);
      chk(sda_oe == 1'b0, "R10 no drive outside ack slot", int'(sda_oe), 0);
      tick(Q);
      scl = 1'b0; tick(Q);
    end
    sda_m = 1'b1; tick(Q);
    scl = 1'b1; tick(Q);
    ack = sda_oe;
    tick(Q);
    scl = 1'b0; tick(Q);
  endtask

  task automatic wait_busy(input int exp, input string req);
    int c = 0;
    for (int k = 0; k < PROG + 40; k++) begin
      tick(1);
      if (busy) c++;
    end
    chk(c == exp, req, c, exp);
  endtask

  task automatic fill_pay(input int seed, input int n);
    for (int i = 0; i < n; i++) pay[i] = 8'((seed * 37 + i * 11 + 5) & 255);
  endtask

  task automatic cmp_mem(input string req);
    for (int a = 0; a < DEP; a++) begin
      if (known[a]) begin
        peek_addr = AW'(a);
        tick(1);
        chk(peek_data == mdl[a], req, int'(peek_data), int'(mdl[a]));
      end
    end
  endtask

  task automatic do_write(input logic [7:0] dev, input logic [7:0] hi, input logic [7:0] lo,
                          input int n, input bit exp_ack, input bit wait_b, input string req);
    bit a;
    bus_start();
    send_byte(dev, a); chk(a == exp_ack, "R2 select ack", int'(a), int'(exp_ack));
    send_byte(hi, a);  chk(a == exp_ack, "R4 first address ack", int'(a), int'(exp_ack));
    send_byte(lo, a);  chk(a == exp_ack, "R4 second address ack", int'(a), int'(exp_ack));
    for (int i = 0; i < n; i++) begin
      send_byte(pay[i], a);
      chk(a == exp_ack, "R5 data ack", int'(a), int'(exp_ack));
    end
    bus_stop();
    if (exp_ack) begin
      for (int i = 0; i < n; i++) begin
        int ad;
        ad = (int'(lo) & 8'hE0) | ((int'(lo) + i) & 31);
        mdl[ad]   = pay[i];
        known[ad] = 1'b1;
      end
    end
    if (wait_b) wait_busy((exp_ack && n > 0) ? PROG : 0, req);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  initial begin
    bit a;
    logic [7:0] v1, v2;
    rst_n = 1'b0; scl = 1'b1; sda_m = 1'b1; strap = 3'b101; peek_addr = '0;
    for (int i = 0; i < DEP; i++) known[i] = 1'b0;
    tick(5);
    chk(sda_oe == 1'b0, "R10 reset oe", int'(sda_oe), 0);
    chk(busy == 1'b0, "R7 reset busy", int'(busy), 0);
    rst_n = 1'b1;
    tick(5);

    // R2: strap against select code, all 64 combinations
    for (int s = 0; s < 8; s++) begin
      for (int c = 0; c < 8; c++) begin
        strap = 3'(s);
        bus_start();
        send_byte({4'hA, 3'(c), 1'b0}, a);
        bus_stop();
        tick(2 * Q);
        chk(a == (s == c), "R2 strap sweep", int'(a), int'(s == c));
        chk(busy == 1'b0, "R6 select only no commit", int'(busy), 0);
      end
    end

    strap = 3'b011;
    // R2: family nibble must be 1010
    for (int f = 0; f < 16; f++) begin
      if (f != 10) begin
        bus_start();
        send_byte({4'(f), 3'b011, 1'b0}, a);
        bus_stop();
        tick(2 * Q);
        chk(a == 1'b0, "R2 family prefix", int'(a), 0);
      end
    end

    // R3: read direction never acknowledged
    bus_start();
    send_byte(8'hA7, a);
    bus_stop();
    tick(2 * Q);
    chk(a == 1'b0, "R3 read select", int'(a), 0);

    // fill every page (upper address byte varies and is ignored)
    for (int p = 0; p < 8; p++) begin
      fill_pay(p + 1, 32);
      do_write(8'hA6, 8'(p * 3 + 1), 8'(p * 32), 32, 1'b1, 1'b1, "R7 busy length");
    end
    cmp_mem("R9 page fill readback");

    // R4: first address byte high bits ignored, partial page
    fill_pay(20, 3);
    do_write(8'hA6, 8'hC3, 8'h25, 3, 1'b1, 1'b1, "R7 busy length");
    cmp_mem("R4 partial write upper bits ignored");

    // R5: 40 bytes from offset 28 wrap inside page 2
    fill_pay(30, 40);
    do_write(8'hA6, 8'h00, 8'h5C, 40, 1'b1, 1'b1, "R7 busy length");
    cmp_mem("R5 wrap overwrite");
    peek_addr = 8'h40; tick(1);
    chk(peek_data == pay[36], "R5 offset 0 holds last wrapped byte", int'(peek_data), int'(pay[36]));

    // R2: write to another strap is ignored entirely
    fill_pay(40, 4);
    do_write(8'hA4, 8'h00, 8'h10, 4, 1'b0, 1'b1, "R2 unselected no busy");
    cmp_mem("R2 unselected write ignored");

    // R6: Stop right after the address
    do_write(8'hA6, 8'h00, 8'h33, 0, 1'b1, 1'b1, "R6 stop without data no busy");
    cmp_mem("R6 stop without data");

    // R6: array unchanged until Stop
    v1 = ~mdl[7];
    bus_start();
    send_byte(8'hA6, a); send_byte(8'h00, a); send_byte(8'h07, a); send_byte(v1, a);
    chk(a == 1'b1, "R5 data ack", int'(a), 1);
    peek_addr = 8'h07; tick(1);
    chk(peek_data == mdl[7], "R6 array unchanged before stop", int'(peek_data), int'(mdl[7]));
    bus_stop();
    wait_busy(PROG, "R7 busy length");
    mdl[7] = v1;
    peek_addr = 8'h07; tick(1);
    chk(peek_data == v1, "R6 committed at stop", int'(peek_data), int'(v1));

    // R1: repeated Start discards the first buffered byte
    v1 = ~mdl[8'h0A];
    v2 = ~mdl[8'h0B];
    bus_start();
    send_byte(8'hA6, a); send_byte(8'h00, a); send_byte(8'h0A, a); send_byte(v1, a);
    bus_start();
    send_byte(8'hA6, a);
    chk(a == 1'b1, "R1 select after repeated start", int'(a), 1);
    send_byte(8'h00, a); send_byte(8'h0B, a); send_byte(v2, a);
    bus_stop();
    wait_busy(PROG, "R7 busy length");
    mdl[8'h0B] = v2;
    cmp_mem("R1 repeated start discards earlier data");

    // R8: silent while programming
    fill_pay(50, 2);
    do_write(8'hA6, 8'h00, 8'h60, 2, 1'b1, 1'b0, "");
    bus_start();
    send_byte(8'hA6, a);
    chk(busy == 1'b1, "R7 still busy during poll", int'(busy), 1);
    chk(a == 1'b0, "R8 select ignored while busy", int'(a), 0);
    send_byte(8'h00, a);
    chk(a == 1'b0, "R8 address ignored while busy", int'(a), 0);
    send_byte(8'h61, a);
    send_byte(8'h99, a);
    chk(a == 1'b0, "R8 data ignored", int'(a), 0);
    bus_stop();
    for (int k = 0; k < PROG && busy; k++) tick(1);
    tick(Q);
    chk(busy == 1'b0, "R8 programming ended", int'(busy), 0);
    cmp_mem("R8 nothing written while busy");
    bus_start();
    send_byte(8'hA6, a);
    bus_stop();
    tick(2 * Q);
    chk(a == 1'b1, "R8 acknowledges after programming", int'(a), 1);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

endmodule